// File: doc/BRIEF.md
# Wavefront memory wait-count scoreboard

This block keeps, for a single wavefront, the number of memory operations still in flight in three classes: vector memory, export, and the combined shared-memory/constant/message class. Each class has an issue pulse and a completion pulse. A memory access with a flat address space is routed by its resolved space: global or private space counts in the vector-memory class, and group (shared) space counts in the shared/constant/message class.

A wait-count load carries three thresholds of different widths. For each class whose field is not all ones, the threshold is armed. The wavefront is held in a wait-count stall while any armed class has more operations outstanding than its threshold. A field of all ones means that class is not waited on and stays unset. Once every armed class is satisfied, all thresholds return to the unset state on the next clock edge. A new load while a stall is in progress replaces all three thresholds.

Top module: `wait_scoreboard`

## Requirements
- R1: After reset all three counts are 0, no threshold is armed (armed_o = 3'b000), stall_o is 0 and underflow_o is 0.
- R2: A class count rises by one for each issue pulse and falls by one for each completion pulse, visible after the clock edge. An issue and a completion of the same class in one cycle leave the count unchanged.
- R3: A flat issue or completion with its shared flag set to 1 counts in the shared/constant/message class. With the flag at 0 it counts in the vector-memory class. A direct vector-memory pulse and a routed flat pulse in the same cycle move the count by two.
- R4: Each count is 6 bits wide and holds at 63 when more issues arrive.
- R5: A completion that would take a count below zero leaves it at 0 and sets underflow_o. underflow_o stays 1 until reset.
- R6: A wait load arms each class whose field is not all ones: vector memory 4'hF, export 3'h7, shared class 5'h1F. A class whose field is all ones stays unset. armed_o bit 0 is vector memory, bit 1 is export and bit 2 is the shared class.
- R7: stall_o is 1 exactly when some armed class has a count strictly greater than its threshold. This is visible in the cycle after the load edge.
- R8: When no armed class is over its threshold and no load is present, all thresholds return to unset on the next edge. This includes the case where the count equals the threshold.
- R9: A load arriving while stall_o is 1 replaces all three armed thresholds, including which classes are armed.
- R10: The shared-class threshold compares over its full 5-bit range. A threshold of 29 stalls at a count of 30 and releases at 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vm_issue_i | input | 1 | Vector-memory operation issued |
| exp_issue_i | input | 1 | Export operation issued |
| lgkm_issue_i | input | 1 | Shared/constant/message operation issued |
| vm_done_i | input | 1 | Vector-memory operation completed |
| exp_done_i | input | 1 | Export operation completed |
| lgkm_done_i | input | 1 | Shared/constant/message operation completed |
| flat_issue_i | input | 1 | Flat-space operation issued |
| flat_issue_shared_i | input | 1 | Issued flat operation resolved to group space |
| flat_done_i | input | 1 | Flat-space operation completed |
| flat_done_shared_i | input | 1 | Completed flat operation resolved to group space |
| wait_load_i | input | 1 | Load the three wait thresholds |
| wait_vm_i | input | 4 | Vector-memory threshold, 4'hF = no wait |
| wait_exp_i | input | 3 | Export threshold, 3'h7 = no wait |
| wait_lgkm_i | input | 5 | Shared-class threshold, 5'h1F = no wait |
| stall_o | output | 1 | Wavefront held in wait-count stall |
| armed_o | output | 3 | Armed flags per class (bit 0 vm, 1 exp, 2 shared) |
| vm_cnt_o | output | 6 | Outstanding vector-memory operations |
| exp_cnt_o | output | 6 | Outstanding export operations |
| lgkm_cnt_o | output | 6 | Outstanding shared-class operations |
| underflow_o | output | 1 | Sticky completion-at-zero error |

## Verification
The hardest state to reach is the saturation at 63: no threshold can express it, and it takes many consecutive issue pulses to get there. The bench issues seventy pulses back to back and then drains the count one completion at a time down to zero, so that the underflow condition is reached at a known count. The release path is also delicate. The bench arms a threshold that the count already meets, and separately replaces the thresholds mid-stall with a set that changes which class is armed. It then watches armed_o drop exactly one edge after the final completion.

// File: rtl/wait_pkg.sv
package wait_pkg;
  localparam int N_CLS    = 3;
  localparam int CLS_VM   = 0;
  localparam int CLS_EXP  = 1;
  localparam int CLS_LGKM = 2;

  function automatic int thr_width(int cls, int vm_w, int exp_w, int lgkm_w);
    if (cls == CLS_VM)  return vm_w;
    if (cls == CLS_EXP) return exp_w;
    return lgkm_w;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wait_cnt_ctr.sv
module wait_cnt_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       inc_i,
  input  logic [1:0]       dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             under_o
);
  localparam int SUM_W   = CNT_W + 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic signed [SUM_W-1:0] sum;
  logic [CNT_W-1:0]        cnt_q, cnt_d;

  always_comb begin
    sum     = $signed(SUM_W'(cnt_q)) + $signed(SUM_W'(inc_i)) - $signed(SUM_W'(dec_i));
    under_o = (sum < 0);
    if (sum < 0)                        cnt_d = '0;
    else if (sum > SUM_W'(CNT_MAX))     cnt_d = CNT_W'(CNT_MAX);
    else                                cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  AST_HOLD_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == dec_i) |=> $stable(cnt_q)); // R2
  AST_SAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(CNT_MAX) && inc_i > dec_i) |=> (cnt_q == CNT_W'(CNT_MAX))); // R4
  AST_ZERO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dec_i > inc_i) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/wait_thr_reg.sv
module wait_thr_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] field_i,
  input  logic         clear_i,
  output logic         armed_o,
  output logic [W-1:0] thr_o
);
  logic         armed_q;
  logic [W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      armed_q <= 1'b0;
      thr_q   <= '0;
    end else if (load_i) begin
      armed_q <= (field_i != {W{1'b1}});
      thr_q   <= field_i;
    end else if (clear_i) begin
      armed_q <= 1'b0;
    end

  assign armed_o = armed_q;
  assign thr_o   = thr_q;

  AST_DISABLED_UNSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && field_i == {W{1'b1}}) |=> !armed_o); // R6
  AST_LOAD_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && field_i != {W{1'b1}}) |=> (armed_o && thr_o == $past(field_i))); // R9
endmodule

// File: rtl/wait_scoreboard.sv
module wait_scoreboard
  import wait_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int VM_THR_W   = 4,
  parameter int EXP_THR_W  = 3,
  parameter int LGKM_THR_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vm_issue_i,
  input  logic                  exp_issue_i,
  input  logic                  lgkm_issue_i,
  input  logic                  vm_done_i,
  input  logic                  exp_done_i,
  input  logic                  lgkm_done_i,
  input  logic                  flat_issue_i,
  input  logic                  flat_issue_shared_i,
  input  logic                  flat_done_i,
  input  logic                  flat_done_shared_i,
  input  logic                  wait_load_i,
  input  logic [VM_THR_W-1:0]   wait_vm_i,
  input  logic [EXP_THR_W-1:0]  wait_exp_i,
  input  logic [LGKM_THR_W-1:0] wait_lgkm_i,
  output logic                  stall_o,
  output logic [N_CLS-1:0]      armed_o,
  output logic [CNT_W-1:0]      vm_cnt_o,
  output logic [CNT_W-1:0]      exp_cnt_o,
  output logic [CNT_W-1:0]      lgkm_cnt_o,
  output logic                  underflow_o
);
  localparam int TWM = max3(VM_THR_W, EXP_THR_W, LGKM_THR_W);

  logic [1:0]       inc   [N_CLS];
  logic [1:0]       dec   [N_CLS];
  logic [CNT_W-1:0] cnt   [N_CLS];
  logic [TWM-1:0]   field [N_CLS];
  logic [TWM-1:0]   thr   [N_CLS];
  logic [N_CLS-1:0] under, armed, sat;
  logic             clear, err_q;

  // flat accesses resolve to vm (global/private) or lgkm (group)
  assign inc[CLS_VM]   = 2'(vm_issue_i) + 2'(flat_issue_i & ~flat_issue_shared_i);
  assign inc[CLS_EXP]  = 2'(exp_issue_i);
  assign inc[CLS_LGKM] = 2'(lgkm_issue_i) + 2'(flat_issue_i & flat_issue_shared_i);
  assign dec[CLS_VM]   = 2'(vm_done_i) + 2'(flat_done_i & ~flat_done_shared_i);
  assign dec[CLS_EXP]  = 2'(exp_done_i);
  assign dec[CLS_LGKM] = 2'(lgkm_done_i) + 2'(flat_done_i & flat_done_shared_i);

  assign field[CLS_VM]   = TWM'(wait_vm_i);
  assign field[CLS_EXP]  = TWM'(wait_exp_i);
  assign field[CLS_LGKM] = TWM'(wait_lgkm_i);

  for (genvar g = 0; g < N_CLS; g++) begin : g_cls
    localparam int TW = thr_width(g, VM_THR_W, EXP_THR_W, LGKM_THR_W);

    wait_cnt_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[g]),
      .dec_i   (dec[g]),
      .cnt_o   (cnt[g]),
      .under_o (under[g])
    );

    wait_thr_reg #(.W(TW)) u_thr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (wait_load_i),
      .field_i (field[g][TW-1:0]),
      .clear_i (clear),
      .armed_o (armed[g]),
      .thr_o   (thr[g][TW-1:0])
    );

    if (TW < TWM) begin : g_pad
      assign thr[g][TWM-1:TW] = '0;
    end

    assign sat[g] = (32'(cnt[g]) <= 32'(thr[g]));
  end

  assign stall_o = |(armed & ~sat);
  assign clear   = (|armed) & ~stall_o & ~wait_load_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      err_q <= 1'b0;
    else if (|under)  err_q <= 1'b1;

  assign armed_o     = armed;
  assign underflow_o = err_q;
  assign vm_cnt_o    = cnt[CLS_VM];
  assign exp_cnt_o   = cnt[CLS_EXP];
  assign lgkm_cnt_o  = cnt[CLS_LGKM];

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o); // R5
  AST_STALL_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (|armed_o)); // R7
  AST_CLEAR_UNSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|armed_o) && !stall_o && !wait_load_i) |=> (armed_o == '0)); // R8
  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o == '0) |-> !stall_o); // R7
endmodule

// File: tb/wait_scoreboard_test.sv
module wait_scoreboard_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vm_is = 0, ex_is = 0, lg_is = 0, vm_dn = 0, ex_dn = 0, lg_dn = 0;
  logic fl_is = 0, fl_is_sh = 0, fl_dn = 0, fl_dn_sh = 0;
  logic ld = 0;
  logic [3:0] w_vm = 0;
  logic [2:0] w_ex = 0;
  logic [4:0] w_lg = 0;
  logic stall, uf;
  logic [2:0] armed;
  logic [5:0] vm_c, ex_c, lg_c;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wait_scoreboard uut (
    .clk_i(clk), .rst_ni(rst_n),
    .vm_issue_i(vm_is), .exp_issue_i(ex_is), .lgkm_issue_i(lg_is),
    .vm_done_i(vm_dn), .exp_done_i(ex_dn), .lgkm_done_i(lg_dn),
    .flat_issue_i(fl_is), .flat_issue_shared_i(fl_is_sh),
    .flat_done_i(fl_dn), .flat_done_shared_i(fl_dn_sh),
    .wait_load_i(ld), .wait_vm_i(w_vm), .wait_exp_i(w_ex), .wait_lgkm_i(w_lg),
    .stall_o(stall), .armed_o(armed),
    .vm_cnt_o(vm_c), .exp_cnt_o(ex_c), .lgkm_cnt_o(lg_c), .underflow_o(uf)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one edge, inputs cleared, sampled at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    {vm_is, ex_is, lg_is, vm_dn, ex_dn, lg_dn, fl_is, fl_is_sh, fl_dn, fl_dn_sh, ld} = '0;
  endtask

  task automatic load(int v, int e, int l);
    ld = 1; w_vm = 4'(v); w_ex = 3'(e); w_lg = 5'(l);
    step();
  endtask

  task automatic t_reset();
    check("R1 vm", vm_c, 0); check("R1 exp", ex_c, 0); check("R1 lgkm", lg_c, 0);
    check("R1 armed", armed, 0); check("R1 stall", stall, 0); check("R1 err", uf, 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) begin vm_is = 1; step(); end
    check("R2 vm inc", vm_c, 3);
    vm_is = 1; vm_dn = 1; step();
    check("R2 same-cycle", vm_c, 3);
    vm_dn = 1; step();
    check("R2 vm dec", vm_c, 2);
  endtask

  task automatic t_flat();
    fl_is = 1; fl_is_sh = 1; step();
    check("R3 flat shared", lg_c, 1);
    check("R3 flat shared vm", vm_c, 2);
    fl_is = 1; step();
    check("R3 flat global", vm_c, 3);
    vm_is = 1; fl_is = 1; step();
    check("R3 dual inc", vm_c, 5);
    vm_dn = 1; fl_dn = 1; step();
    check("R3 dual dec", vm_c, 3);
    fl_dn = 1; fl_dn_sh = 1; step();
    check("R3 flat shared done", lg_c, 0);
  endtask

  task automatic t_wait();
    ex_is = 1; step(); ex_is = 1; step();
    check("R2 exp", ex_c, 2);
    load(1, 7, 31);
    check("R6 armed vm only", armed, 3'b001);
    check("R7 stall vm", stall, 1);
    load(15, 1, 31);
    check("R9 replaced armed", armed, 3'b010);
    check("R9 stall exp", stall, 1);
    ex_dn = 1; step();
    check("R7 released", stall, 0);
    check("R8 still armed", armed, 3'b010);
    step();
    check("R8 unset", armed, 0);
    load(15, 7, 31);
    check("R6 all disabled", armed, 0);
    check("R6 no stall", stall, 0);
    load(3, 7, 31);
    check("R8 equal no stall", stall, 0);
    check("R8 equal armed", armed, 3'b001);
    step();
    check("R8 equal unset", armed, 0);
  endtask

  task automatic t_lgkm();
    for (int i = 0; i < 30; i++) begin lg_is = 1; step(); end
    check("R10 lgkm cnt", lg_c, 30);
    load(15, 7, 29);
    check("R10 stall at 30", stall, 1);
    lg_dn = 1; step();
    check("R10 release at 29", stall, 0);
    step();
    check("R10 unset", armed, 0);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 70; i++) begin vm_is = 1; step(); end
    check("R4 saturate", vm_c, 63);
    for (int i = 0; i < 63; i++) begin vm_dn = 1; step(); end
    check("R5 drained", vm_c, 0);
    check("R5 no err yet", uf, 0);
    vm_dn = 1; step();
    check("R5 floor", vm_c, 0);
    check("R5 err set", uf, 1);
    step();
    check("R5 err sticky", uf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_flat();
    t_wait();
    t_lgkm();
    t_sat();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule